// File: doc/BRIEF.md
# Flag-Setting Integer ALU

This block is the arithmetic and logic stage of a simple integer datapath. It takes an operation code and two operands and forms the result combinationally in the same cycle. It also keeps a four-bit condition store that holds the negative, zero, carry and overflow indications. The store updates on the next rising clock edge, and only when the operation asks for it.

Ten operations produce a result that the surrounding datapath may write back:

- four arithmetic operations: add, add with carry, subtract, and subtract with carry;
- four bitwise operations: AND, OR, XOR, and clear-bits;
- two moves: pass the second operand, or pass its complement.

Three further operations only test the operands. They always update the store and never raise the write enable. The carry-in for the chained arithmetic forms comes from the stored carry flag. Subtraction treats carry as "no borrow".

Top module: `flag_alu`

## Requirements
- R1: A synchronous active-high reset clears all four flags to 0. The flag port carries N at bit 3, Z at bit 2, C at bit 1 and V at bit 0.
- R2: With opcode 0 (add) the result is a+b. With 1 (add with carry) it is a+b+C. With 2 (subtract) it is a-b. With 3 (subtract with carry) it is a-b+C-1. All are modulo 2^32, C is the stored carry flag, and the result is valid in the same cycle as the inputs.
- R3: The remaining result-producing opcodes are 4 (a AND b), 5 (a OR b), 6 (a XOR b), 7 (a AND NOT b), 8 (b) and 9 (NOT b).
- R4: The write enable is high for opcodes 0 to 9 and low for opcodes 10 to 15. Opcodes 13 to 15 drive a result of 0.
- R5: On a flag update, N takes bit 31 of the result and Z is set exactly when the full 32-bit result is zero.
- R6: On an arithmetic flag update, C takes the carry out of bit 31 of a + b' + cin. Here b' is b for the add forms and NOT b for the subtract forms, so after subtract or compare C=1 means a >= b unsigned.
- R7: On an arithmetic flag update, V is set exactly when a and b' share a sign and the result's sign differs from it.
- R8: Flag updates by opcodes 4 to 9, 11 and 12 change only N and Z and leave C and V as they were.
- R9: Opcodes 0 to 9 update the flags only when set_flags is 1. Opcodes 10 to 12 update them regardless of set_flags. Opcodes 13 to 15 never update them. New flags appear after the next rising clock edge.
- R10: Opcode 10 (compare) sets all four flags from a-b. Opcode 11 (test) sets N and Z from a AND b. Opcode 12 (test-equal) sets N and Z from a XOR b. While these opcodes are applied, the result port shows that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag store |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| set_flags_i | input | 1 | Request flag update for opcodes 0 to 9 |
| result_o | output | 32 | Combinational result |
| res_we_o | output | 1 | Result write enable |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The assertions check the following on every cycle:

- the flags hold when no update is requested;
- C and V hold across updates that touch only N and Z;
- Z and N track the previous result after an update;
- an overflow indication only ever comes with equal operand signs and a flipped result sign;
- compare and test never raise the write enable.

The exact arithmetic values need the bench's scenarios against an independent model. These include the chained carry-in and borrow behaviour of the two carry-using forms, and the mapping of every opcode to its result.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_AND = 4'd4,
    OP_ORR = 4'd5,
    OP_EOR = 4'd6,
    OP_BIC = 4'd7,
    OP_MOV = 4'd8,
    OP_MVN = 4'd9,
    OP_CMP = 4'd10,
    OP_TST = 4'd11,
    OP_TEQ = 4'd12,
    OP_NA0 = 4'd13,
    OP_NA1 = 4'd14,
    OP_NA2 = 4'd15
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             invert_b,
  input  logic             cin,
  output logic [WIDTH-1:0] b_eff,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] wide;

  always_comb begin
    b_eff = invert_b ? ~b : b;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, cin};
    sum   = wide[WIDTH-1:0];
    cout  = wide[WIDTH];
    ovf   = (a[MSB] ^ sum[MSB]) & (b_eff[MSB] ^ sum[MSB]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int WIDTH = 32
) (
  input  alu_pkg::alu_op_e op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);
  import alu_pkg::*;

  always_comb begin
    case (op)
      OP_AND, OP_TST: y = a & b;
      OP_ORR:         y = a | b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_BIC:         y = a & ~b;
      OP_MOV:         y = b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       upd_nz,
  input  logic       upd_cv,
  input  logic       n_in,
  input  logic       z_in,
  input  logic       c_in,
  input  logic       v_in,
  output logic [3:0] flags
);
  import alu_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= 4'b0000;
    end else begin
      if (upd_nz) begin
        flags[FLAG_N] <= n_in;
        flags[FLAG_Z] <= z_in;
      end
      if (upd_cv) begin
        flags[FLAG_C] <= c_in;
        flags[FLAG_V] <= v_in;
      end
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (flags == 4'b0000))
    else $error("reset did not clear flags");

  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!upd_nz && !upd_cv) |=> $stable(flags))
    else $error("flags changed without update");

  assert_cv_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!upd_cv) |=> $stable(flags[1:0]))
    else $error("C/V changed on NZ-only update");
endmodule

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             set_flags_i,
  output logic [WIDTH-1:0] result_o,
  output logic             res_we_o,
  output logic [3:0]       flags_o
);
  import alu_pkg::*;

  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  logic             is_arith;
  logic             is_logic;
  logic             is_probe;
  logic             invert_b;
  logic             cin;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic             ovf;
  logic [WIDTH-1:0] log_y;
  logic             upd_nz;
  logic             upd_cv;

  assign op = alu_op_e'(op_i);

  always_comb begin
    is_arith = 1'b0;
    is_logic = 1'b0;
    is_probe = 1'b0;
    invert_b = 1'b0;
    cin      = 1'b0;
    case (op)
      OP_ADD: is_arith = 1'b1;
      OP_ADC: begin is_arith = 1'b1; cin = flags_o[FLAG_C]; end
      OP_SUB: begin is_arith = 1'b1; invert_b = 1'b1; cin = 1'b1; end
      OP_SBC: begin is_arith = 1'b1; invert_b = 1'b1; cin = flags_o[FLAG_C]; end
      OP_CMP: begin is_arith = 1'b1; is_probe = 1'b1; invert_b = 1'b1; cin = 1'b1; end
      OP_AND, OP_ORR, OP_EOR, OP_BIC, OP_MOV, OP_MVN: is_logic = 1'b1;
      OP_TST, OP_TEQ: begin is_logic = 1'b1; is_probe = 1'b1; end
      default: ;
    endcase
  end

  alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(a_i), .b(b_i), .invert_b(invert_b), .cin(cin),
    .b_eff(b_eff), .sum(sum), .cout(cout), .ovf(ovf)
  );

  alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op), .a(a_i), .b(b_i), .y(log_y)
  );

  always_comb begin
    if (is_arith)      result_o = sum;
    else if (is_logic) result_o = log_y;
    else               result_o = '0;
    res_we_o = (is_arith || is_logic) && !is_probe;
    upd_nz   = is_probe || ((is_arith || is_logic) && set_flags_i);
    upd_cv   = upd_nz && is_arith;
  end

  alu_flags u_flags (
    .clk(clk), .rst(rst),
    .upd_nz(upd_nz), .upd_cv(upd_cv),
    .n_in(result_o[MSB]), .z_in(result_o == '0),
    .c_in(cout), .v_in(ovf),
    .flags(flags_o)
  );

  assert_probe_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    (op_i >= 4'd10) |-> !res_we_o)
    else $error("write enable on non-writing opcode");

  assert_zero_track_R5: assert property (@(posedge clk) disable iff (rst)
    upd_nz |=> (flags_o[FLAG_Z] == ($past(result_o) == '0)) &&
               (flags_o[FLAG_N] == $past(result_o[MSB])))
    else $error("N/Z do not follow result");

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (is_arith && ovf) |-> ((a_i[MSB] == b_eff[MSB]) && (sum[MSB] != a_i[MSB])))
    else $error("overflow without sign flip");
endmodule

// File: tb/flag_alu_bench.sv
module flag_alu_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_i = 4'd0;
  logic [31:0] a_i = '0;
  logic [31:0] b_i = '0;
  logic        set_i = 1'b0;
  logic [31:0] result_o;
  logic        res_we_o;
  logic [3:0]  flags_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [3:0] mflags = 4'b0000;

  always #10 clk = ~clk;

  flag_alu u_flag_alu (
    .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .set_flags_i(set_i), .result_o(result_o), .res_we_o(res_we_o), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic s, input logic [3:0] f,
                       output logic [31:0] r, output logic we,
                       output logic [3:0] nf, output logic un, output logic ucv);
    logic [32:0] w;
    logic [31:0] bb;
    logic arith;
    arith = (op <= 4'd3) || (op == 4'd10);
    bb = (op == 4'd2 || op == 4'd3 || op == 4'd10) ? ~b : b;
    w = 33'd0;
    case (op)
      4'd0: w = {1'b0, a} + {1'b0, b};
      4'd1: w = {1'b0, a} + {1'b0, b} + {32'd0, f[1]};
      4'd2, 4'd10: w = {1'b0, a} + {1'b0, ~b} + 33'd1;
      4'd3: w = {1'b0, a} + {1'b0, ~b} + {32'd0, f[1]};
      4'd4, 4'd11: w = {1'b0, a & b};
      4'd5: w = {1'b0, a | b};
      4'd6, 4'd12: w = {1'b0, a ^ b};
      4'd7: w = {1'b0, a & ~b};
      4'd8: w = {1'b0, b};
      4'd9: w = {1'b0, ~b};
      default: w = 33'd0;
    endcase
    r = w[31:0];
    we = (op <= 4'd9);
    un = (op >= 4'd10 && op <= 4'd12) || (op <= 4'd9 && s);
    ucv = un && arith;
    nf = f;
    if (un) begin
      nf[3] = r[31];
      nf[2] = (r == 32'd0);
    end
    if (ucv) begin
      nf[1] = w[32];
      nf[0] = (a[31] == bb[31]) && (r[31] != a[31]);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic s);
    logic [31:0] er;
    logic ewe, un, ucv;
    logic [3:0] ef;
    string rt;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; set_i = s;
    #1;
    model(op, a, b, s, mflags, er, ewe, ef, un, ucv);
    if (op <= 4'd3) rt = "R2";
    else if (op <= 4'd9) rt = "R3";
    else if (op <= 4'd12) rt = "R10";
    else rt = "R4";
    chk(rt, result_o, er);
    chk("R4", {31'd0, res_we_o}, {31'd0, ewe});
    @(posedge clk);
    #1;
    if (!un) begin
      chk("R9", {28'd0, flags_o}, {28'd0, ef});
    end else begin
      chk("R5", {30'd0, flags_o[3:2]}, {30'd0, ef[3:2]});
      if (ucv) begin
        chk("R6", {31'd0, flags_o[1]}, {31'd0, ef[1]});
        chk("R7", {31'd0, flags_o[0]}, {31'd0, ef[0]});
      end else begin
        chk("R8", {30'd0, flags_o[1:0]}, {30'd0, ef[1:0]});
      end
    end
    mflags = ef;
  endtask

  function automatic logic [31:0] pick();
    case ($urandom % 8)
      0: return 32'h0000_0000;
      1: return 32'h7fff_ffff;
      2: return 32'h8000_0000;
      3: return 32'hffff_ffff;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", {28'd0, flags_o}, 28'd0);
    // R6 R7: signed overflow and unsigned carry corners
    apply(4'd0, 32'h7fff_ffff, 32'h0000_0001, 1'b1);
    chk("R7", {28'd0, flags_o}, 32'h9);
    apply(4'd0, 32'hffff_ffff, 32'h0000_0001, 1'b1);
    chk("R6", {28'd0, flags_o}, 32'h6);
    apply(4'd1, 32'h0000_000f, 32'hffff_ffff, 1'b1);
    chk("R2", result_o, 32'h0000_000f);
    apply(4'd3, 32'h0000_000f, 32'hffff_ffff, 1'b1);
    chk("R2", result_o, 32'h0000_000f);
    apply(4'd3, 32'h0000_0005, 32'h0000_0005, 1'b0);
    // R10: compare of equal operands, then less-than
    apply(4'd10, 32'h0000_0023, 32'h0000_0023, 1'b0);
    chk("R10", {28'd0, flags_o}, 32'h6);
    apply(4'd10, 32'h0000_0011, 32'h0000_0023, 1'b0);
    chk("R10", {28'd0, flags_o}, 32'h8);
    apply(4'd11, 32'h0000_000f, 32'h0000_00f0, 1'b0);
    apply(4'd12, 32'h0000_000f, 32'h0000_0018, 1'b0);
    apply(4'd7, 32'h0000_0055, 32'h0000_0061, 1'b1);
    apply(4'd9, 32'h0000_000c, 32'h0000_000c, 1'b1);
    apply(4'd14, 32'h1234_5678, 32'h0, 1'b1);
    apply(4'd2, 32'h8000_0000, 32'h0000_0001, 1'b0);
    for (int i = 0; i < 3000; i++) begin
      apply(4'($urandom % 16), pick(), pick(), 1'($urandom % 2));
    end
    // R1: reset in mid-run clears flags
    apply(4'd10, 32'h0, 32'h1, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", {28'd0, flags_o}, 32'h0);
    rst = 1'b0;
    mflags = 4'b0000;
    apply(4'd1, 32'h1, 32'h1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule